// File: doc/BRIEF.md
# Serial Wire Raw Bit Sequence Engine

This block clocks an arbitrary run of bits over a two-wire serial debug link without any packet framing. A host starts a sequence with one info word that carries a bit count and a direction flag. In drive mode the engine pulls bytes through a byte-wide valid/ready handshake and shifts them onto the data line. In capture mode it samples the data line and hands the packed bytes back through a second valid/ready handshake.

The serial clock is made from the system clock by a programmable half-period count. Every bit takes one low phase and one high phase. The link clock idles high. When the host is slow, either because no write byte is available or because a captured byte has not been taken, the engine waits with the clock held high. The pad itself stays outside the block. The engine only provides an output enable and an output value, and takes the input value.

Top module: `swd_seq_engine`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy`, `done`, `wr_ready`, `rd_valid` and `swdio_oe` are 0 and `swclk` is 1.
- R2: A pulse on `start` while idle begins a sequence. `info[5:0]` gives the number of serial clock pulses, and the value 0 means 64 pulses.
- R3: `info[6]` = 1 selects capture mode, in which `swdio_oe` stays 0 for the whole sequence. `info[6]` = 0 selects drive mode, in which `swdio_oe` is 1 while `busy` is 1.
- R4: In drive mode, bytes are accepted on `wr_valid`/`wr_ready`. Each byte is sent least significant bit first, one bit per serial clock. A new byte is requested after 8 bits. Bits of the final byte beyond the count are never driven.
- R5: In capture mode, the first sampled bit of each byte appears in `rd_data[0]`. A final byte holding k < 8 bits is right-aligned in `rd_data[k-1:0]`, with the upper bits zero. Bytes are delivered on `rd_valid`/`rd_ready`.
- R6: Each low phase and each high phase of `swclk` lasts `half_period` system clocks, and a `half_period` of 0 acts as 1. The value is latched at `start`, so later changes do not affect the running sequence.
- R7: In capture mode, `swdio_in` is sampled on the last system clock of the low phase, just before `swclk` rises.
- R8: In drive mode, `swdio_out` changes only on the system clock where `swclk` falls. It holds steady through the following rising edge.
- R9: While waiting for a write byte or for `rd_ready`, `swclk` stays 1 and no further clock pulse is produced. A pending `rd_data` does not change.
- R10: `done` is 1 for exactly one system clock when a sequence ends, and the engine is idle on the next clock. In drive mode the end comes after the last high phase. In capture mode it comes after the last byte has been accepted.
- R11: A `start` pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| info | input | 7 | [5:0] clock count (0 = 64), [6] capture mode |
| half_period | input | 8 | System clocks per serial clock half-period |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock pulse at sequence end |
| wr_data | input | 8 | Byte to drive, LSB first |
| wr_valid | input | 1 | `wr_data` is available |
| wr_ready | output | 1 | Engine takes `wr_data` this clock if valid |
| rd_data | output | 8 | Captured byte, first bit in bit 0 |
| rd_valid | output | 1 | `rd_data` is available |
| rd_ready | input | 1 | Consumer takes `rd_data` |
| swclk | output | 1 | Serial clock to the link |
| swdio_oe | output | 1 | Data line output enable |
| swdio_out | output | 1 | Data line output value |
| swdio_in | input | 1 | Data line input value |

## Verification
A wrong count register shows up at the ports as an extra or missing `swclk` rise. That difference is visible within one bit period of the expected end, together with a misplaced `done`. A wrong in-byte bit index or a wrong shift register shows up at the next rising edge as an out-of-order bit on `swdio_out`. In capture mode it shows up at the next byte delivery as a misaligned `rd_data`, which is most visible on a partial last byte. A divider that is not latched or is reloaded wrongly shows in the very next low phase, whose length no longer matches the half-period given at start.

// File: rtl/swd_seq_pkg.sv
`timescale 1ns/1ps
// Shared constants and state encoding for the raw serial wire sequence engine.
// Assumes byte-wide host transfers; the byte width is fixed by the link format.
package swd_seq_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_PUSH,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/swd_seq_timer.sv
`timescale 1ns/1ps
// Half-period down counter. A load sets it to period-1; expire is high on the
// last system clock of the phase. Assumes period is never zero (caller clamps).
module swd_seq_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] period,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_q;

    // Reload at each phase start, otherwise count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/swd_seq_packer.sv
`timescale 1ns/1ps
// Capture accumulator. Each sampled bit enters at the top and older bits move
// toward bit 0; the output is right-aligned by the number of unfilled places.
// Assumes no more than BYTE_W shifts between clears.
module swd_seq_packer
    import swd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] acc_q;
    logic [BIDX_W:0]   fill_q;
    logic [BIDX_W:0]   gap;

    // Collect sampled bits and count how many positions hold real data.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            acc_q  <= {bit_in, acc_q[BYTE_W-1:1]};
            fill_q <= fill_q + 1'b1;
        end
    end

    // Drop the unfilled low positions so the first bit lands in bit 0.
    always_comb begin
        gap      = (BIDX_W+1)'(BYTE_W) - fill_q;
        byte_out = acc_q >> gap;
    end
endmodule

// File: rtl/swd_seq_ctrl.sv
`timescale 1ns/1ps
// Sequence controller: walks the bit phases, counts remaining bits and bit
// position within the byte, runs both byte handshakes and drives the link.
// Assumes the timer and packer are wired as in swd_seq_engine.
module swd_seq_ctrl
    import swd_seq_pkg::*;
#(
    parameter int unsigned COUNT_W = 6,
    parameter int unsigned DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COUNT_W:0]  info,
    input  logic [DIV_W-1:0]  half_period,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              rd_ready,
    input  logic              tmr_expire,
    output logic              busy,
    output logic              done,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic              swclk,
    output logic              swdio_oe,
    output logic              swdio_out,
    output logic              tmr_load,
    output logic [DIV_W-1:0]  tmr_period,
    output logic              pk_clear,
    output logic              pk_shift
);
    localparam int unsigned     REM_W   = COUNT_W + 1;
    localparam logic [REM_W-1:0] REM_MAX = REM_W'(1) << COUNT_W;
    localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(BYTE_W - 1);

    seq_state_e        state_q, state_n;
    logic              cap_q;
    logic [DIV_W-1:0]  half_q;
    logic [REM_W-1:0]  rem_q, rem_init;
    logic [BIDX_W-1:0] bidx_q;
    logic [BYTE_W-1:0] shift_q, shift_n;
    logic              swclk_q, out_q;
    logic [DIV_W-1:0]  half_eff;
    logic              last_bit, byte_end, enter_low;

    // Clamp the half period and expand a zero count to the full range.
    always_comb begin
        half_eff = (half_period == '0) ? DIV_W'(1) : half_period;
        rem_init = (info[COUNT_W-1:0] == '0) ? REM_MAX : {1'b0, info[COUNT_W-1:0]};
        last_bit = (rem_q == REM_W'(1));
        byte_end = (bidx_q == BIDX_LAST);
    end

    // Next-state selection across fetch, bit phases, delivery and finish.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_n = info[COUNT_W] ? ST_LOW : ST_FETCH;
            ST_FETCH: if (wr_valid) state_n = ST_LOW;
            ST_LOW:   if (tmr_expire) state_n = ST_HIGH;
            ST_HIGH: begin
                if (tmr_expire) begin
                    if (last_bit || byte_end) begin
                        if (cap_q)         state_n = ST_PUSH;
                        else if (last_bit) state_n = ST_DONE;
                        else               state_n = ST_FETCH;
                    end else begin
                        state_n = ST_LOW;
                    end
                end
            end
            ST_PUSH:  if (rd_ready) state_n = (rem_q == '0) ? ST_DONE : ST_LOW;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Next content of the drive shift register.
    always_comb begin
        shift_n = shift_q;
        if (state_q == ST_FETCH && wr_valid) begin
            shift_n = wr_data;
        end else if (state_q == ST_HIGH && tmr_expire) begin
            shift_n = shift_q >> 1;
        end
    end

    assign enter_low = (state_n == ST_LOW) && (state_q != ST_LOW);

    // State, configuration latch, bit counters and link output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= 1'b0;
            half_q  <= DIV_W'(1);
            rem_q   <= '0;
            bidx_q  <= '0;
            shift_q <= '0;
            swclk_q <= 1'b1;
            out_q   <= 1'b1;
        end else begin
            state_q <= state_n;
            shift_q <= shift_n;
            swclk_q <= (state_n != ST_LOW);
            if (state_q == ST_IDLE && start) begin
                cap_q  <= info[COUNT_W];
                half_q <= half_eff;
                rem_q  <= rem_init;
                bidx_q <= '0;
            end
            if (state_q == ST_HIGH && tmr_expire) begin
                rem_q  <= rem_q - 1'b1;
                bidx_q <= byte_end ? '0 : bidx_q + 1'b1;
            end
            if (enter_low && !cap_q) begin
                out_q <= shift_n[0];
            end
        end
    end

    // Phase timer control and capture accumulator control.
    always_comb begin
        tmr_load   = (state_n != state_q) && (state_n == ST_LOW || state_n == ST_HIGH);
        tmr_period = (state_q == ST_IDLE) ? half_eff : half_q;
        pk_clear   = (state_q == ST_IDLE && start) || (state_q == ST_PUSH && rd_ready);
        pk_shift   = (state_q == ST_LOW) && tmr_expire && cap_q;
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign wr_ready  = (state_q == ST_FETCH);
    assign rd_valid  = (state_q == ST_PUSH);
    assign swclk     = swclk_q;
    assign swdio_oe  = busy && !cap_q;
    assign swdio_out = out_q;
endmodule

// File: rtl/swd_seq_engine.sv
`timescale 1ns/1ps
// Top of the raw serial wire bit sequence engine: controller, half-period
// timer and capture packer. Assumes the pad tristate lives outside.
module swd_seq_engine
    import swd_seq_pkg::*;
#(
    parameter int unsigned COUNT_W = 6,
    parameter int unsigned DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COUNT_W:0]  info,
    input  logic [DIV_W-1:0]  half_period,
    output logic              busy,
    output logic              done,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              swclk,
    output logic              swdio_oe,
    output logic              swdio_out,
    input  logic              swdio_in
);
    logic             tmr_load, tmr_expire, pk_clear, pk_shift;
    logic [DIV_W-1:0] tmr_period;

    swd_seq_ctrl #(.COUNT_W(COUNT_W), .DIV_W(DIV_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .info       (info),
        .half_period(half_period),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .rd_ready   (rd_ready),
        .tmr_expire (tmr_expire),
        .busy       (busy),
        .done       (done),
        .wr_ready   (wr_ready),
        .rd_valid   (rd_valid),
        .swclk      (swclk),
        .swdio_oe   (swdio_oe),
        .swdio_out  (swdio_out),
        .tmr_load   (tmr_load),
        .tmr_period (tmr_period),
        .pk_clear   (pk_clear),
        .pk_shift   (pk_shift)
    );

    swd_seq_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .period(tmr_period),
        .expire(tmr_expire)
    );

    swd_seq_packer u_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pk_clear),
        .shift_en(pk_shift),
        .bit_in  (swdio_in),
        .byte_out(rd_data)
    );
endmodule

// File: rtl/swd_seq_engine_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for swd_seq_engine, attached by bind.
module swd_seq_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       wr_ready,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       swclk,
    input logic       swdio_oe,
    input logic       swdio_out
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk && !swdio_oe && !wr_ready && !rd_valid && !done));

    p_fetch_only_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> swdio_oe);

    p_out_moves_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swdio_oe && $past(swdio_oe) && !$fell(swclk)) |-> $stable(swdio_out));

    p_fetch_clk_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> swclk);

    p_push_clk_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> swclk);

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind swd_seq_engine swd_seq_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .wr_ready (wr_ready),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .swclk    (swclk),
    .swdio_oe (swdio_oe),
    .swdio_out(swdio_out)
);

// File: tb/tb_swd_seq_engine.sv
`timescale 1ns/1ps
module tb_swd_seq_engine;
    localparam int CW = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW:0]   info = '0;
    logic [DW-1:0] half_period = 8'd1;
    logic          busy, done, wr_ready, rd_valid;
    logic [7:0]    wr_data = '0;
    logic          wr_valid = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_ready = 1'b1;
    logic          swclk, swdio_oe, swdio_out, swdio_in;

    int checks = 0;
    int errors = 0;
    logic wd = 1'b0;

    // expectations and target model
    logic          exp_oe = 1'b1;
    int            exp_half = 1;
    logic [127:0]  tgt = '0;
    logic [7:0]    tx [0:7];

    // monitor state
    logic [6:0]    rise_cnt = '0;
    int            low_run = 0, low_bad = 0, out_bad = 0, oe_bad = 0;
    int            done_cnt = 0, cap_cnt = 0;
    logic          prev_clk = 1'b1, fall_out = 1'b1;
    logic [127:0]  drv_bits = '0;
    logic [7:0]    cap_bytes [0:7];

    always #10 clk = ~clk;

    assign swdio_in = tgt[rise_cnt];

    swd_seq_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .info(info),
        .half_period(half_period), .busy(busy), .done(done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .swclk(swclk), .swdio_oe(swdio_oe), .swdio_out(swdio_out),
        .swdio_in(swdio_in)
    );

    // Link monitor, sampled on the falling system clock edge.
    always @(negedge clk) begin
        if (start && !busy) begin
            rise_cnt <= '0; low_run <= 0; low_bad <= 0; out_bad <= 0;
            oe_bad <= 0; done_cnt <= 0; cap_cnt <= 0; prev_clk <= 1'b1;
        end else begin
            if (!swclk) low_run <= low_run + 1;
            if (prev_clk && !swclk) fall_out <= swdio_out;
            if (!prev_clk && swclk) begin
                rise_cnt <= rise_cnt + 7'd1;
                drv_bits[rise_cnt] <= swdio_out;
                low_run <= 0;
                if (low_run != exp_half) low_bad <= low_bad + 1;
                if (swdio_oe != exp_oe) oe_bad <= oe_bad + 1;
                if (exp_oe && swdio_out != fall_out) out_bad <= out_bad + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
            if (rd_valid && rd_ready) begin
                cap_bytes[cap_cnt[2:0]] <= rd_data;
                cap_cnt <= cap_cnt + 1;
            end
            prev_clk <= swclk;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic launch(input logic cap, input int n, input int h);
        exp_oe      = !cap;
        exp_half    = (h == 0) ? 1 : h;
        info        = {cap, n[CW-1:0]};
        half_period = h[DW-1:0];
        start       = 1'b1;
        cyc(1);
        start       = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        int guard = 0;
        wr_data  = b;
        wr_valid = 1'b1;
        while (!wr_ready && guard < 5000) begin cyc(1); guard++; end
        cyc(1);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (done_cnt == 0 && g < 20000) begin cyc(1); g++; end
        cyc(2);
        chk("R10", "done pulse count", done_cnt, 1);
        chk("R10", "busy after end", int'(busy), 0);
    endtask

    task automatic chk_drive(input int n);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (drv_bits[i[6:0]] != tx[i / 8][i % 8]) bad++;
        chk("R4", "mismatched driven bits", bad, 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R1", "swclk at reset", int'(swclk), 1);
        chk("R1", "oe at reset", int'(swdio_oe), 0);
        chk("R1", "handshakes at reset", int'({done, wr_ready, rd_valid}), 0);
    endtask

    task automatic t_drive_basic();
        tx[0] = 8'hA5; tx[1] = 8'h3C;
        launch(1'b0, 13, 2);
        chk("R3", "oe during drive", int'(swdio_oe), 1);
        feed(tx[0]);
        feed(tx[1]);
        wait_done();
        chk("R2", "clock pulses for 13", int'(rise_cnt), 13);
        chk_drive(13);
        chk("R6", "low phase length half=2", low_bad, 0);
        chk("R3", "oe at rising edges", oe_bad, 0);
        chk("R8", "out changed inside bit", out_bad, 0);
        chk("R1", "oe after drive", int'(swdio_oe), 0);
    endtask

    task automatic t_drive_full();
        for (int i = 0; i < 8; i++) tx[i] = 8'(i * 37) ^ 8'h5A;
        launch(1'b0, 0, 0);
        for (int i = 0; i < 8; i++) feed(tx[i]);
        wait_done();
        chk("R2", "count 0 gives 64 pulses", int'(rise_cnt), 64);
        chk_drive(64);
        chk("R6", "half 0 acts as 1", low_bad, 0);
        chk("R8", "out stable across rise", out_bad, 0);
    endtask

    task automatic t_capture_partial();
        tgt = 128'h0000_0000_0000_0000_0000_0000_0000_06B3;
        launch(1'b1, 11, 3);
        chk("R3", "oe in capture", int'(swdio_oe), 0);
        wait_done();
        chk("R2", "clock pulses for 11", int'(rise_cnt), 11);
        chk("R5", "captured byte count", cap_cnt, 2);
        chk("R7", "first full byte", int'(cap_bytes[0]), int'(tgt[7:0]));
        chk("R5", "partial byte right aligned", int'(cap_bytes[1]), int'({5'b0, tgt[10:8]}));
        chk("R3", "oe low at rises", oe_bad, 0);
        chk("R6", "low phase length half=3", low_bad, 0);
    endtask

    task automatic t_capture_stall();
        logic [7:0] snap;
        logic [6:0] rsnap;
        int bad = 0, g = 0;
        tgt = 128'h0000_0000_0000_0000_0000_0000_0000_C15E;
        rd_ready = 1'b0;
        launch(1'b1, 16, 1);
        while (!rd_valid && g < 5000) begin cyc(1); g++; end
        snap = rd_data; rsnap = rise_cnt;
        chk("R5", "byte presented while stalled", int'(snap), int'(tgt[7:0]));
        repeat (12) begin
            if (!swclk || !rd_valid || rd_data != snap || rise_cnt != rsnap) bad++;
            cyc(1);
        end
        chk("R9", "stall on capture consumer", bad, 0);
        rd_ready = 1'b1;
        wait_done();
        chk("R5", "second byte", int'(cap_bytes[1]), int'(tgt[15:8]));
        chk("R2", "clock pulses for 16", int'(rise_cnt), 16);
    endtask

    task automatic t_drive_stall_ignore();
        int bad = 0, g = 0;
        tx[0] = 8'hC3; tx[1] = 8'h01;
        launch(1'b0, 9, 2);
        feed(tx[0]);
        info = {1'b1, 6'd3};
        half_period = 8'd5;
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        while (!wr_ready && g < 5000) begin cyc(1); g++; end
        repeat (10) begin
            if (!swclk || rise_cnt != 7'd8) bad++;
            cyc(1);
        end
        chk("R9", "stall waiting for write byte", bad, 0);
        feed(tx[1]);
        wait_done();
        chk("R11", "start while busy ignored", int'(rise_cnt), 9);
        chk_drive(9);
        chk("R6", "half period latched at start", low_bad, 0);
        chk("R11", "mode unchanged by late start", oe_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin tx[i] = '0; cap_bytes[i] = '0; end
        fork
            begin
                cyc(3);
                rst_n = 1'b1;
                cyc(1);
                t_reset();
                t_drive_basic();
                t_drive_full();
                t_capture_partial();
                t_capture_stall();
                t_drive_stall_ignore();
            end
            begin
                repeat (200000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule